// File: doc/BRIEF.md
# Clock Recovery Loop State Controller

This block supervises a digital clock-recovery loop. It decides whether the loop runs free, is trying to acquire, is locked, has briefly lost phase lock, or is holding its last frequency. It does not contain the loop filter, the phase detector or the holdover averaging. It sees status flags and a one-second tick. It returns an encoded state, a locked flag and a request to switch the selected reference.

Timed conditions are measured in ticks of `tick_i`. Each qualifier counts ticks while its condition holds, and restarts from zero as soon as the condition drops or the state changes. Lock is declared once phase lock has held for `LOCK_TICKS` ticks. An acquisition that has not locked after `TMO_TICKS` ticks forces a reference switch. A selected reference that stays invalid for `INV_TICKS` ticks, with no other valid input, sends the loop back to free-run.

Top module: `clk_loop_ctrl`

## Requirements
- R1: While `rst_ni` is low and on the first cycle after it rises, `state_o` is 3'b001 (free-run), and `locked_o` and `switch_req_o` are 0.
- R2: In free-run, a valid selected reference (`ref_valid_i`=1) moves the state to prelocked (3'b101) on the next clock edge.
- R3: From prelocked (3'b101), prelocked2 (3'b110) or loss-of-lock (3'b011), the state becomes locked (3'b100) on the `LOCK_TICKS`-th tick seen while `phase_lock_i` and `ref_valid_i` are both continuously high. Any cycle with either input low restarts the count.
- R4: In prelocked or prelocked2, with `any_valid_i`=1, the state goes to prelocked2 and a switch is requested in any of three cases: the reference is invalid, `revert_hi_i` is high, or the `TMO_TICKS`-th tick arrives while `phase_lock_i` has stayed low. With `any_valid_i`=0, none of these requests a switch.
- R5: In prelocked or prelocked2, the state returns to free-run on the `INV_TICKS`-th tick seen while `ref_valid_i` has stayed low with no valid input.
- R6: In locked, `ref_valid_i`=0 moves the state to holdover (3'b010). With the reference valid, `phase_lock_i`=0 moves it to loss-of-lock (3'b011). Loss-of-lock also enters holdover when the reference turns invalid.
- R7: In holdover with `manual_hold_i`=1 the state stays in holdover. With `manual_hold_i`=0 and `any_valid_i`=1 it moves to prelocked2 and requests a switch.
- R8: In locked with the reference valid, `revert_hi_i`=1 together with `any_valid_i`=1 moves the state to prelocked2 and requests a switch.
- R9: `state_o` only takes the six codes above, and `locked_o` is 1 exactly when `state_o` is 3'b100.
- R10: `switch_req_o` is high for the one cycle after each edge at which a switch decision is taken, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse once per second |
| ref_valid_i | input | 1 | Selected reference is valid |
| phase_lock_i | input | 1 | Loop reports phase lock to the selected reference |
| any_valid_i | input | 1 | At least one input clock is valid |
| revert_hi_i | input | 1 | Revertive mode sees a valid higher-priority input |
| manual_hold_i | input | 1 | Stay in holdover until released |
| state_o | output | 3 | Encoded loop state |
| locked_o | output | 1 | Loop is in the locked state |
| switch_req_o | output | 1 | Request to select another reference |

## Verification
Directed sequences walk each transition. They hit each timed window one tick short of its limit and then exactly at it. This separates an off-by-one count from a correct one, and separates a qualifier that restarts on a dropped condition from one that keeps its count. Holdover is tried with manual hold both set and clear while a valid input is present, which shows whether the hold control is honoured. A long run then drives slowly toggling flags and ticks at random and compares the outputs every cycle with a model in the bench. This covers the priorities between conditions that are true in the same cycle, such as lock qualification against a switch, and invalidity with and without another valid input.

// File: rtl/clk_loop_pkg.sv
package clk_loop_pkg;
  typedef enum logic [2:0] {
    ST_FREE = 3'b001,
    ST_HOLD = 3'b010,
    ST_LOL  = 3'b011,
    ST_LOCK = 3'b100,
    ST_PRE  = 3'b101,
    ST_PRE2 = 3'b110
  } loop_st_e;

  localparam int unsigned NUM_QUAL = 3;
  localparam int unsigned Q_LOCK   = 0;
  localparam int unsigned Q_INV    = 1;
  localparam int unsigned Q_NOLOCK = 2;
endpackage

// File: rtl/loop_tick_qual.sv
module loop_tick_qual #(
  parameter int unsigned LIMIT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic cond_i,
  input  logic clr_i,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign hit_o = tick_i && cond_i && (cnt_q == CW'(LIMIT - 1));

  // saturates at LIMIT so a held condition fires only once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            cnt_q <= '0;
    else if (clr_i || !cond_i)              cnt_q <= '0;
    else if (tick_i && cnt_q != CW'(LIMIT)) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/loop_fsm.sv
module loop_fsm
  import clk_loop_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ref_valid_i,
  input  logic                phase_lock_i,
  input  logic                any_valid_i,
  input  logic                revert_hi_i,
  input  logic                manual_hold_i,
  input  logic [NUM_QUAL-1:0] hit_i,
  output logic [NUM_QUAL-1:0] cond_o,
  output logic                clr_o,
  output loop_st_e            state_o,
  output logic                switch_req_o
);
  loop_st_e st_q, st_d;
  logic     sw_d, sw_q;
  logic     in_pre;

  assign in_pre = (st_q == ST_PRE) || (st_q == ST_PRE2);

  always_comb begin
    cond_o           = '0;
    cond_o[Q_LOCK]   = phase_lock_i && ref_valid_i && (in_pre || st_q == ST_LOL);
    cond_o[Q_INV]    = !ref_valid_i && in_pre;
    cond_o[Q_NOLOCK] = !phase_lock_i && in_pre;
  end

  always_comb begin
    st_d = st_q;
    sw_d = 1'b0;
    unique case (st_q)
      ST_FREE: if (ref_valid_i) st_d = ST_PRE;
      ST_PRE, ST_PRE2: begin
        if (hit_i[Q_LOCK]) st_d = ST_LOCK;
        else if (any_valid_i && (!ref_valid_i || hit_i[Q_NOLOCK] || revert_hi_i)) begin
          st_d = ST_PRE2;
          sw_d = 1'b1;
        end else if (hit_i[Q_INV]) st_d = ST_FREE;
      end
      ST_LOCK: begin
        if (!ref_valid_i) st_d = ST_HOLD;
        else if (revert_hi_i && any_valid_i) begin
          st_d = ST_PRE2;
          sw_d = 1'b1;
        end else if (!phase_lock_i) st_d = ST_LOL;
      end
      ST_LOL: begin
        if (!ref_valid_i)        st_d = ST_HOLD;
        else if (hit_i[Q_LOCK])  st_d = ST_LOCK;
      end
      ST_HOLD: if (!manual_hold_i && any_valid_i) begin
        st_d = ST_PRE2;
        sw_d = 1'b1;
      end
      default: st_d = ST_FREE;
    endcase
  end

  assign clr_o = (st_d != st_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_FREE;
      sw_q <= 1'b0;
    end else begin
      st_q <= st_d;
      sw_q <= sw_d;
    end
  end

  assign state_o      = st_q;
  assign switch_req_o = sw_q;
endmodule

// File: rtl/clk_loop_ctrl.sv
module clk_loop_ctrl
  import clk_loop_pkg::*;
#(
  parameter int unsigned LOCK_TICKS = 2,
  parameter int unsigned INV_TICKS  = 2,
  parameter int unsigned TMO_TICKS  = 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       ref_valid_i,
  input  logic       phase_lock_i,
  input  logic       any_valid_i,
  input  logic       revert_hi_i,
  input  logic       manual_hold_i,
  output logic [2:0] state_o,
  output logic       locked_o,
  output logic       switch_req_o
);
  localparam int unsigned QUAL_LIM [NUM_QUAL] = '{LOCK_TICKS, INV_TICKS, TMO_TICKS};

  logic [NUM_QUAL-1:0] cond, hit;
  logic                clr;
  loop_st_e            st;

  for (genvar g = 0; g < NUM_QUAL; g++) begin : g_qual
    loop_tick_qual #(.LIMIT(QUAL_LIM[g])) u_qual (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .cond_i (cond[g]),
      .clr_i  (clr),
      .hit_o  (hit[g])
    );
  end

  loop_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ref_valid_i   (ref_valid_i),
    .phase_lock_i  (phase_lock_i),
    .any_valid_i   (any_valid_i),
    .revert_hi_i   (revert_hi_i),
    .manual_hold_i (manual_hold_i),
    .hit_i         (hit),
    .cond_o        (cond),
    .clr_o         (clr),
    .state_o       (st),
    .switch_req_o  (switch_req_o)
  );

  assign state_o  = st;
  assign locked_o = (st == ST_LOCK);
endmodule

// File: rtl/clk_loop_ctrl_chk.sv
module clk_loop_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       ref_valid_i,
  input logic       phase_lock_i,
  input logic       any_valid_i,
  input logic       revert_hi_i,
  input logic       manual_hold_i,
  input logic [2:0] state_o,
  input logic       locked_o,
  input logic       switch_req_o
);
  AST_LEGAL_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 3'b000 && state_o != 3'b111);  // R9
  AST_FREE_TO_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'b001 && ref_valid_i) |=> state_o == 3'b101);  // R2
  AST_LOCK_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> ($past(state_o) == 3'b101 || $past(state_o) == 3'b110 ||
                         $past(state_o) == 3'b011));  // R3
  AST_HOLD_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'b010 && $past(state_o) != 3'b010) |->
      ($past(state_o) == 3'b100 || $past(state_o) == 3'b011));  // R6
  AST_MANUAL_STAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'b010 && manual_hold_i) |=> state_o == 3'b010);  // R7
  AST_SWITCH_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_req_o |-> $past(any_valid_i));  // R4
  AST_SWITCH_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_req_o |-> state_o == 3'b110);  // R10
endmodule

bind clk_loop_ctrl clk_loop_ctrl_chk chk_i (.*);

// File: tb/clk_loop_ctrl_tb_top.sv
module clk_loop_ctrl_tb_top;
  localparam int LOCK_T = 2;
  localparam int INV_T  = 2;
  localparam int TMO_T  = 100;
  localparam logic [2:0] FREE = 3'b001, HOLD = 3'b010, LOL = 3'b011,
                         LOCK = 3'b100, PRE = 3'b101, PRE2 = 3'b110;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 0, ref_valid_i = 0, phase_lock_i = 0, any_valid_i = 0;
  logic revert_hi_i = 0, manual_hold_i = 0;
  logic [2:0] state_o;
  logic locked_o, switch_req_o;

  int checks = 0, fails = 0;
  logic [2:0] m_st;
  logic m_sw;
  int m_cnt [3];

  always #10 clk_i = ~clk_i;

  clk_loop_ctrl dut_i (.*);

  task automatic chk(input logic ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lim(input int i);
    return (i == 0) ? LOCK_T : (i == 1) ? INV_T : TMO_T;
  endfunction

  // bench model advance for one clock edge from current inputs
  task automatic model_step();
    logic in_pre;
    logic [2:0] c, h;
    logic [2:0] nx;
    logic sw;
    in_pre = (m_st == PRE) || (m_st == PRE2);
    c[0] = phase_lock_i && ref_valid_i && (in_pre || m_st == LOL);
    c[1] = !ref_valid_i && in_pre;
    c[2] = !phase_lock_i && in_pre;
    for (int i = 0; i < 3; i++) h[i] = tick_i && c[i] && (m_cnt[i] == lim(i) - 1);
    nx = m_st; sw = 0;
    case (m_st)
      FREE: if (ref_valid_i) nx = PRE;
      PRE, PRE2:
        if (h[0]) nx = LOCK;
        else if (any_valid_i && (!ref_valid_i || h[2] || revert_hi_i)) begin nx = PRE2; sw = 1; end
        else if (h[1]) nx = FREE;
      LOCK:
        if (!ref_valid_i) nx = HOLD;
        else if (revert_hi_i && any_valid_i) begin nx = PRE2; sw = 1; end
        else if (!phase_lock_i) nx = LOL;
      LOL:
        if (!ref_valid_i) nx = HOLD;
        else if (h[0]) nx = LOCK;
      HOLD: if (!manual_hold_i && any_valid_i) begin nx = PRE2; sw = 1; end
      default: nx = FREE;
    endcase
    for (int i = 0; i < 3; i++)
      if (nx != m_st || !c[i]) m_cnt[i] = 0;
      else if (tick_i && m_cnt[i] != lim(i)) m_cnt[i]++;
    m_st = nx; m_sw = sw;
  endtask

  task automatic cyc(input string tag);
    model_step();
    @(posedge clk_i);
    @(negedge clk_i);
    chk(state_o == m_st, tag, {1'b0, state_o}, {1'b0, m_st});
    chk(locked_o == (m_st == LOCK), "R9", {3'b0, locked_o}, {3'b0, m_st == LOCK});
    chk(switch_req_o == m_sw, "R10", {3'b0, switch_req_o}, {3'b0, m_sw});
  endtask

  task automatic tick_cyc(input string tag);
    tick_i = 1; cyc(tag); tick_i = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    m_st = FREE; m_sw = 0;
    for (int i = 0; i < 3; i++) m_cnt[i] = 0;
    repeat (3) @(negedge clk_i);
    chk(state_o == FREE && !locked_o && !switch_req_o, "R1", {1'b0, state_o}, {1'b0, FREE});
    rst_ni = 1;
    cyc("R1");
    chk(state_o == FREE, "R1", {1'b0, state_o}, {1'b0, FREE});

    // acquisition and lock
    ref_valid_i = 1; cyc("R2");
    chk(state_o == PRE, "R2", {1'b0, state_o}, {1'b0, PRE});
    phase_lock_i = 1; any_valid_i = 1;
    tick_cyc("R3"); cyc("R3");
    chk(state_o == PRE, "R3", {1'b0, state_o}, {1'b0, PRE});
    tick_cyc("R3");
    chk(state_o == LOCK && locked_o, "R3", {1'b0, state_o}, {1'b0, LOCK});

    // loss of lock, restart of qualification
    phase_lock_i = 0; cyc("R6");
    chk(state_o == LOL, "R6", {1'b0, state_o}, {1'b0, LOL});
    phase_lock_i = 1; tick_cyc("R3");
    phase_lock_i = 0; cyc("R3");
    phase_lock_i = 1; tick_cyc("R3");
    chk(state_o == LOL, "R3", {1'b0, state_o}, {1'b0, LOL});
    tick_cyc("R3");
    chk(state_o == LOCK, "R3", {1'b0, state_o}, {1'b0, LOCK});

    // revertive switch from locked
    revert_hi_i = 1; cyc("R8");
    chk(state_o == PRE2 && switch_req_o, "R8", {1'b0, state_o}, {1'b0, PRE2});
    revert_hi_i = 0; phase_lock_i = 0; cyc("R10");
    chk(!switch_req_o, "R10", {3'b0, switch_req_o}, 4'h0);

    // lock timeout in prelocked2
    for (int i = 0; i < TMO_T - 1; i++) begin tick_cyc("R4"); cyc("R4"); end
    chk(state_o == PRE2 && !switch_req_o, "R4", {3'b0, switch_req_o}, 4'h0);
    tick_cyc("R4");
    chk(switch_req_o, "R4", {3'b0, switch_req_o}, 4'h1);

    // invalid reference with no valid input
    ref_valid_i = 0; any_valid_i = 0; cyc("R4");
    chk(!switch_req_o && state_o == PRE2, "R4", {3'b0, switch_req_o}, 4'h0);
    tick_cyc("R5");
    chk(state_o == PRE2, "R5", {1'b0, state_o}, {1'b0, PRE2});
    tick_cyc("R5");
    chk(state_o == FREE, "R5", {1'b0, state_o}, {1'b0, FREE});

    // holdover, manual then automatic
    ref_valid_i = 1; phase_lock_i = 1; cyc("R2");
    tick_cyc("R3"); tick_cyc("R3");
    ref_valid_i = 0; cyc("R6");
    chk(state_o == HOLD, "R6", {1'b0, state_o}, {1'b0, HOLD});
    manual_hold_i = 1; any_valid_i = 1;
    repeat (4) cyc("R7");
    chk(state_o == HOLD, "R7", {1'b0, state_o}, {1'b0, HOLD});
    manual_hold_i = 0; cyc("R7");
    chk(state_o == PRE2 && switch_req_o, "R7", {1'b0, state_o}, {1'b0, PRE2});

    // invalid reference with another valid input switches at once
    ref_valid_i = 0; cyc("R4");
    chk(switch_req_o, "R4", {3'b0, switch_req_o}, 4'h1);

    // random phase against the model
    for (int n = 0; n < 30000; n++) begin
      tick_i = ($urandom % 4) == 0;
      if ($urandom % 12 == 0) ref_valid_i   = ~ref_valid_i;
      if ($urandom % 10 == 0) phase_lock_i  = ~phase_lock_i;
      if ($urandom % 14 == 0) any_valid_i   = ~any_valid_i;
      if ($urandom % 40 == 0) revert_hi_i   = ~revert_hi_i;
      if ($urandom % 25 == 0) manual_hold_i = ~manual_hold_i;
      cyc("R9");
    end
    tick_i = 0;
    finish_run();
  end
endmodule